// File: doc/BRIEF.md
# Round-Robin One-Hot Request Masker

This block picks exactly one winner from a vector of N request lines. A one-hot priority vector marks where the search begins. The search tests that marked position first, then moves toward higher indices and wraps from bit N-1 back to bit 0. The first set request it meets is the only bit passed to the output, and every other bit is cleared. This selection path is purely combinational and has zero latency.

A registered arbiter wrapper sits around a second copy of the same selection logic. It keeps its own one-hot pointer and registers the grant, so a grant appears one clock after the requests it answers. After each nonzero grant the pointer moves to the position just above the granted bit, wrapping at the top, so every requester gets served in turn. The clock and reset drive only this wrapper.

The wrapper has no enumerated state of its own. Its whole state is the pointer register and the registered grant. The parameter WIDTH sets N, must be at least 2, and defaults to 4.

Top module: `rr_masker_top`

## Requirements
- R1: `mask_o` has at most one bit set, and that bit is also set in `req_i`. `mask_o` follows `req_i` and `prio_i` in the same cycle.
- R2: Let p be the index of the single set bit of `prio_i`. `mask_o` keeps the first set bit of `req_i` in the order p, p+1, ..., N-1, 0, ..., p-1. Bit p itself is tested first.
- R3: With `req_i` = 4'b1001 and `prio_i` = 4'b0010, `mask_o` is 4'b1000.
- R4: An all-zero `req_i` gives an all-zero `mask_o`. It also gives an all-zero `grant_o` one clock later.
- R5: After each rising edge, `grant_o` equals the R2 selection applied to the `req_i` value and the `ptr_o` value present just before that edge.
- R6: When the grant captured at an edge has bit g set, `ptr_o` after that edge has bit (g+1) mod N set, and only that bit. When the captured grant is zero, `ptr_o` keeps its value.
- R7: While `rst_n` is low and after it is released, `ptr_o` is 4'b0001 (bit 0 set) and `grant_o` is 0 until the first edge with reset high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the registered arbiter |
| rst_n | input | 1 | Active-low synchronous reset of the arbiter |
| req_i | input | WIDTH | Request lines, shared by both paths |
| prio_i | input | WIDTH | One-hot search origin for the combinational path |
| mask_o | output | WIDTH | Combinational one-hot selection |
| grant_o | output | WIDTH | Registered one-hot grant from the pointer-driven path |
| ptr_o | output | WIDTH | Current one-hot pointer of the arbiter |

## Verification
The bench sweeps every request pattern against every priority position and compares each result with a scan computed in software. This catches a design that skips the pointer bit itself: it would return 1000 instead of 0010 for requests 1010 with origin 0010. It also catches a design that fails to wrap past the top: it would return zero or the wrong low bit when all set requests sit below the origin. The registered path is run with a request stream that mixes in all-zero cycles. A pointer that moves on an empty grant, or that lands on the granted bit rather than the one above it, makes the grant sequence drift from the model. The same stream also shows an off-by-one in grant latency as a mismatch.

// File: rtl/rr_mask_core.sv
module rr_mask_core #(
    parameter int WIDTH      = 4,
    parameter bit CHECK_PRIO = 1'b1
) (
    input  logic [WIDTH-1:0] req_i,
    input  logic [WIDTH-1:0] prio_i,
    output logic [WIDTH-1:0] mask_o
);
    localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

    logic [WIDTH-1:0] at_or_above;
    logic [WIDTH-1:0] upper_req;
    logic [WIDTH-1:0] upper_pick;
    logic [WIDTH-1:0] lower_pick;

    // Bits at or above the origin: complement of (origin - 1).
    always_comb begin
        at_or_above = ~(prio_i - ONE);
        upper_req   = req_i & at_or_above;
        upper_pick  = upper_req & (~upper_req + ONE);
        lower_pick  = req_i & (~req_i + ONE);
        mask_o      = (upper_req != '0) ? upper_pick : lower_pick;
    end

    always_comb begin
        // R1: single bit, drawn from the requests
        a_r1_single_subset: assert ($onehot0(mask_o) && ((mask_o & ~req_i) == '0))
            else $error("mask not a single request bit");
        // R4: no request, no selection
        a_r4_zero_in_zero_out: assert ((req_i != '0) || (mask_o == '0))
            else $error("mask set with no requests");
        // R2: a nonzero request must produce a selection
        a_r2_some_pick: assert ((req_i == '0) || (mask_o != '0))
            else $error("requests present but nothing selected");
        if (CHECK_PRIO) begin
            a_r2_prio_onehot: assert ($onehot(prio_i))
                else $error("priority origin is not one-hot");
        end
    end
endmodule

// File: rtl/rr_ptr_stage.sv
module rr_ptr_stage #(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] grant_d,
    output logic [WIDTH-1:0] grant_q,
    output logic [WIDTH-1:0] ptr_q
);
    localparam logic [WIDTH-1:0] PTR_RESET = WIDTH'(1);

    logic [WIDTH-1:0] ptr_next;

    always_comb begin
        if (grant_d != '0) begin
            ptr_next = {grant_d[WIDTH-2:0], grant_d[WIDTH-1]};
        end else begin
            ptr_next = ptr_q;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q   <= PTR_RESET;
            grant_q <= '0;
        end else begin
            ptr_q   <= ptr_next;
            grant_q <= grant_d;
        end
    end

    // R6: pointer stays one-hot once out of reset
    a_r6_ptr_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> $onehot(ptr_q));

    // R6: a grant at bit g moves the pointer to g+1, wrapping
    a_r6_advance: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_d != '0) |=> (ptr_q[0] == $past(grant_d[WIDTH-1]))
                            && (ptr_q[WIDTH-1:1] == $past(grant_d[WIDTH-2:0])));

    // R6: an empty grant leaves the pointer alone
    a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_d == '0) |=> $stable(ptr_q));

    // R5: one cycle from selection to registered grant
    a_r5_latency: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (grant_q == $past(grant_d)));
endmodule

// File: rtl/rr_masker_top.sv
module rr_masker_top #(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] req_i,
    input  logic [WIDTH-1:0] prio_i,
    output logic [WIDTH-1:0] mask_o,
    output logic [WIDTH-1:0] grant_o,
    output logic [WIDTH-1:0] ptr_o
);
    logic [WIDTH-1:0] rr_pick;
    logic [WIDTH-1:0] ptr_q;

    initial begin
        a_width_min: assert (WIDTH >= 2) else $error("WIDTH must be at least 2");
    end

    // Zero-latency path driven by the external origin.
    rr_mask_core #(.WIDTH(WIDTH), .CHECK_PRIO(1'b1)) u_ext_core (
        .req_i  (req_i),
        .prio_i (prio_i),
        .mask_o (mask_o)
    );

    // Pointer-driven path; pointer legality is checked in the stage.
    rr_mask_core #(.WIDTH(WIDTH), .CHECK_PRIO(1'b0)) u_rr_core (
        .req_i  (req_i),
        .prio_i (ptr_q),
        .mask_o (rr_pick)
    );

    rr_ptr_stage #(.WIDTH(WIDTH)) u_stage (
        .clk     (clk),
        .rst_n   (rst_n),
        .grant_d (rr_pick),
        .grant_q (grant_o),
        .ptr_q   (ptr_q)
    );

    assign ptr_o = ptr_q;
endmodule

// File: tb/tb_rr_masker_top.sv
`timescale 1ns/1ps
module tb_rr_masker_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] req = 4'b0000;
    logic [3:0] prio = 4'b0001;
    logic [3:0] mask, grant, ptr;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    rr_masker_top #(.WIDTH(4)) dut (
        .clk(clk), .rst_n(rst_n), .req_i(req), .prio_i(prio),
        .mask_o(mask), .grant_o(grant), .ptr_o(ptr)
    );

    function automatic logic [3:0] ref_pick(logic [3:0] r, int pos);
        for (int k = 0; k < 4; k++) begin
            int idx;
            idx = (pos + k) % 4;
            if (r[idx]) return 4'(1 << idx);
        end
        return 4'b0000;
    endfunction

    task automatic chk(string tag, logic [3:0] act, logic [3:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%b expected=%b", tag, act, exp);
        end
    endtask

    initial begin
        #100000;
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int pos_m;
        logic [3:0] exp_g;

        // R7: reset state
        repeat (3) @(posedge clk);
        #1;
        chk("R7 ptr in reset", ptr, 4'b0001);
        chk("R7 grant in reset", grant, 4'b0000);

        // R1/R2/R4: exhaustive combinational sweep
        for (int p = 0; p < 4; p++) begin
            for (int r = 0; r < 16; r++) begin
                prio = 4'(1 << p);
                req  = 4'(r);
                #1;
                if (r == 0) chk("R4 zero requests", mask, 4'b0000);
                else        chk("R2 R1 scan with wrap", mask, ref_pick(4'(r), p));
            end
        end

        // R3: worked example
        prio = 4'b0010; req = 4'b1001; #1;
        chk("R3 example 1001/0010", mask, 4'b1000);

        // R7: still in reset, nothing registered
        chk("R7 grant held at zero", grant, 4'b0000);
        chk("R7 ptr held at bit0", ptr, 4'b0001);

        // Registered arbiter run
        @(negedge clk);
        rst_n = 1'b1;
        req = 4'b0000;
        pos_m = 0;
        for (int i = 0; i < 60; i++) begin
            @(negedge clk);
            if (i % 6 == 0) req = 4'b0000;
            else if (i % 5 == 0) req = 4'b1111;
            else req = 4'((i * 5 + 3) % 16);
            exp_g = ref_pick(req, pos_m);
            @(posedge clk);
            #1;
            if (exp_g != 4'b0000) begin
                for (int b = 0; b < 4; b++) if (exp_g[b]) pos_m = (b + 1) % 4;
            end
            if (req == 4'b0000) chk("R4 registered zero grant", grant, 4'b0000);
            else                chk("R5 registered grant", grant, exp_g);
            chk("R6 pointer advance/hold", ptr, 4'(1 << pos_m));
        end

        // R6: explicit wrap from bit 3 to bit 0
        @(negedge clk);
        req = 4'b1000;
        exp_g = ref_pick(req, pos_m);
        @(posedge clk); #1;
        chk("R6 wrap grant", grant, 4'b1000);
        chk("R6 wrap pointer", ptr, 4'b0001);

        // R7: reassert reset mid-run
        @(negedge clk);
        rst_n = 1'b0;
        req = 4'b0100;
        @(posedge clk); #1;
        chk("R7 reset clears grant", grant, 4'b0000);
        chk("R7 reset restores ptr", ptr, 4'b0001);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule